// File: doc/BRIEF.md
# Strided Interleave Transfer Address Generator

This block sequences the addresses of one interleaved block transfer between a large main memory and a small local scratch memory. A transfer moves a total number of 16-byte quadwords in chunks. Inside a chunk both sides advance by one quadword per beat. Between chunks the main-memory side leaps over a programmed gap of quadwords that is never addressed, while the scratch side stays packed. The chunk length and the gap are taken from the inputs when the transfer starts. A chunk length of zero means the whole transfer is one chunk.

A host loads the total count, chunk length, gap, transfer direction and the two base byte addresses, then pulses start. The block presents one beat per quadword on a valid/ready handshake carrying both byte addresses and the direction. A separate data mover performs the actual copy. The count still to be moved can be watched on an output. A one-cycle done pulse ends each transfer. The direction changes only the direction bit: addressing is identical both ways.

Top module: `stride_dma_agen`

## Requirements
- R1: Beat valid is high only while a transfer is in progress, and exactly as many beats are accepted as the total count loaded at start; valid is low in the done cycle and while idle.
- R2: The transfer is cut into chunks of min(chunk length, quadwords still remaining), with the chunk length sampled at start, until the remaining count is zero.
- R3: A chunk length of zero, or one not smaller than the total, makes the whole transfer a single contiguous chunk on the main-memory side.
- R4: The scratch address of the first beat is the scratch base; every later beat's scratch address is the previous one plus 16, across chunk borders too, wrapping at the scratch address width.
- R5: The main-memory address of the first beat is the main base; within a chunk each beat's main address is the previous one plus 16.
- R6: The first beat of each later chunk has main address equal to the previous chunk's first address plus (chunk length + gap) × 16, i.e. the gap quadwords are skipped.
- R7: A beat is consumed only at a clock edge where valid and ready are both high; while valid is high and ready low, addresses, direction and remaining count hold.
- R8: The remaining-count output equals total minus accepted beats during a transfer, and reads zero in the done cycle and afterwards until the next start.
- R9: A start with a total count of zero raises done in the cycle after start without presenting any beat.
- R10: Done is high for exactly one cycle, the cycle after the edge that accepts the last beat.
- R11: A start pulse during a transfer or in the done cycle is ignored: the running transfer continues unchanged and no new transfer begins.
- R12: The direction input is sampled at start (0 = scratch to main memory, 1 = main memory to scratch) and is shown unchanged on the beat direction output for every beat of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| dir_i | input | 1 | Direction: 0 scratch to main, 1 main to scratch |
| total_qw_i | input | CNT_W | Total quadwords to move |
| chunk_qw_i | input | CNT_W | Quadwords per chunk, 0 = one chunk |
| skip_qw_i | input | CNT_W | Quadwords skipped on the main side after each chunk |
| main_base_i | input | MADDR_W | Main-memory start byte address |
| scr_base_i | input | SADDR_W | Scratch start byte address |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | Consumer accepts the beat |
| beat_main_addr_o | output | MADDR_W | Main-memory byte address of the beat |
| beat_scr_addr_o | output | SADDR_W | Scratch byte address of the beat |
| beat_dir_o | output | 1 | Direction of the transfer |
| remain_qw_o | output | CNT_W | Quadwords not yet accepted |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume the address base inputs are quadword aligned and that the total, chunk and gap values fit their widths without the main-side address wrapping mid-check; they make no assumption about when ready rises or falls. The stimulus draws aligned bases, totals up to 40, chunk lengths from zero past the total and small gaps from a seeded generator. Ready is randomised with several acceptance rates, including long stall stretches, and extra start pulses with different settings are thrown in during a transfer and in its done cycle.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int unsigned QW_BYTES = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdma_state_e;

    typedef enum logic {
        DIR_TO_MAIN = 1'b0,
        DIR_TO_SCR  = 1'b1
    } sdma_dir_e;

    // Length of the next chunk: a zero or oversize request takes all that is left.
    function automatic logic [31:0] chunk_len(input logic [31:0] req, input logic [31:0] left);
        if (req == 32'd0 || req > left)
            return left;
        return req;
    endfunction

endpackage

// File: rtl/sdma_fsm.sv
module sdma_fsm
    import sdma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic total_zero_i,
    input  logic fire_i,
    input  logic last_i,
    output logic load_o,
    output logic valid_o,
    output logic done_o
);

    sdma_state_e state_q, state_d;

    assign load_o  = start_i && (state_q == ST_IDLE);
    assign valid_o = (state_q == ST_RUN);
    assign done_o  = (state_q == ST_FIN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_o) state_d = total_zero_i ? ST_FIN : ST_RUN;
            ST_RUN:  if (fire_i && last_i) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R10: done never lasts two cycles
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: empty transfer finishes on the next cycle
    assert_zero_total_R9: assert property (@(posedge clk) disable iff (rst)
        (load_o && total_zero_i) |=> (done_o && !valid_o));

    // R1: a non-empty start always presents a beat next
    assert_start_run_R1: assert property (@(posedge clk) disable iff (rst)
        (load_o && !total_zero_i) |=> valid_o);

endmodule

// File: rtl/sdma_count.sv
module sdma_count
    import sdma_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [CNT_W-1:0] req_now_i,
    input  logic [CNT_W-1:0] req_hold_i,
    input  logic             fire_i,
    output logic [CNT_W-1:0] rem_o,
    output logic             last_o,
    output logic             chunk_end_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] rem_next;

    assign rem_next    = rem_q - ONE;
    assign rem_o       = rem_q;
    assign last_o      = (rem_q == ONE);
    assign chunk_end_o = (left_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            rem_q  <= total_i;
            left_q <= CNT_W'(chunk_len(32'(req_now_i), 32'(total_i)));
        end else if (fire_i) begin
            rem_q <= rem_next;
            if (chunk_end_o)
                left_q <= CNT_W'(chunk_len(32'(req_hold_i), 32'(rem_next)));
            else
                left_q <= left_q - ONE;
        end
    end

    // R2: a chunk is never empty nor longer than what remains
    assert_chunk_live_R2: assert property (@(posedge clk) disable iff (rst)
        (rem_q != '0) |-> (left_q != '0 && left_q <= rem_q));

endmodule

// File: rtl/sdma_step.sv
module sdma_step
    import sdma_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic         fire_i,
    input  logic         chunk_end_i,
    input  logic [W-1:0] gap_bytes_i,
    output logic [W-1:0] addr_o
);

    localparam logic [W-1:0] STEP = W'(QW_BYTES);

    logic [W-1:0] addr_q;
    logic [W-1:0] extra;

    assign extra  = chunk_end_i ? gap_bytes_i : '0;
    assign addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load_i)
            addr_q <= base_i;
        else if (fire_i)
            addr_q <= addr_q + STEP + extra;
    end

endmodule

// File: rtl/stride_dma_agen.sv
module stride_dma_agen
    import sdma_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned MADDR_W = 32,
    parameter int unsigned SADDR_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               dir_i,
    input  logic [CNT_W-1:0]   total_qw_i,
    input  logic [CNT_W-1:0]   chunk_qw_i,
    input  logic [CNT_W-1:0]   skip_qw_i,
    input  logic [MADDR_W-1:0] main_base_i,
    input  logic [SADDR_W-1:0] scr_base_i,
    output logic               beat_valid_o,
    input  logic               beat_ready_i,
    output logic [MADDR_W-1:0] beat_main_addr_o,
    output logic [SADDR_W-1:0] beat_scr_addr_o,
    output logic               beat_dir_o,
    output logic [CNT_W-1:0]   remain_qw_o,
    output logic               done_o
);

    localparam logic [MADDR_W-1:0] M_STEP = MADDR_W'(QW_BYTES);
    localparam logic [SADDR_W-1:0] S_STEP = SADDR_W'(QW_BYTES);

    typedef struct packed {
        sdma_dir_e        dir;
        logic [CNT_W-1:0] chunk;
        logic [CNT_W-1:0] skip;
    } sdma_cfg_t;

    sdma_cfg_t          cfg_q;
    logic               load;
    logic               fire;
    logic               last;
    logic               chunk_end;
    logic [MADDR_W-1:0] gap_bytes;

    assign fire       = beat_valid_o && beat_ready_i;
    assign gap_bytes  = MADDR_W'({skip_hold_ext(cfg_q.skip), 4'h0});
    assign beat_dir_o = cfg_q.dir;

    function automatic logic [CNT_W-1:0] skip_hold_ext(input logic [CNT_W-1:0] s);
        return s;
    endfunction

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{dir: DIR_TO_MAIN, chunk: '0, skip: '0};
        else if (load)
            cfg_q <= '{dir: sdma_dir_e'(dir_i), chunk: chunk_qw_i, skip: skip_qw_i};
    end

    sdma_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .total_zero_i (total_qw_i == '0),
        .fire_i       (fire),
        .last_i       (last),
        .load_o       (load),
        .valid_o      (beat_valid_o),
        .done_o       (done_o)
    );

    sdma_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .total_i     (total_qw_i),
        .req_now_i   (chunk_qw_i),
        .req_hold_i  (cfg_q.chunk),
        .fire_i      (fire),
        .rem_o       (remain_qw_o),
        .last_o      (last),
        .chunk_end_o (chunk_end)
    );

    sdma_step #(.W(MADDR_W)) u_main (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .base_i      (main_base_i),
        .fire_i      (fire),
        .chunk_end_i (chunk_end),
        .gap_bytes_i (gap_bytes),
        .addr_o      (beat_main_addr_o)
    );

    sdma_step #(.W(SADDR_W)) u_scr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .base_i      (scr_base_i),
        .fire_i      (fire),
        .chunk_end_i (1'b0),
        .gap_bytes_i ('0),
        .addr_o      (beat_scr_addr_o)
    );

    // R7: a stalled beat keeps its contents
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_main_addr_o)
            && $stable(beat_scr_addr_o) && $stable(remain_qw_o) && $stable(beat_dir_o)));

    // R4: scratch side is packed
    assert_scr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && !last) |=> (beat_scr_addr_o == $past(beat_scr_addr_o) + S_STEP));

    // R5: main side inside a chunk
    assert_main_step_R5: assert property (@(posedge clk) disable iff (rst)
        (fire && !last && !chunk_end) |=> (beat_main_addr_o == $past(beat_main_addr_o) + M_STEP));

    // R6: main side jumps over the gap between chunks
    assert_main_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && !last && chunk_end) |=> (beat_main_addr_o == $past(beat_main_addr_o) + M_STEP + gap_bytes));

    // R8: remaining count is zero when done
    assert_rem_zero_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (remain_qw_o == '0));

    // R1: no beat offered in the done cycle
    assert_no_beat_done_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !beat_valid_o);

    // R10: last accepted beat is followed by done
    assert_last_done_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && last) |=> done_o);

    // R11: a start during a transfer does not disturb it
    assert_start_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && start_i && !(fire && last)) |=> (beat_valid_o && remain_qw_o <= $past(remain_qw_o)));

    // R12: direction held across beats
    assert_dir_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (fire && !last) |=> $stable(beat_dir_o));

endmodule

// File: tb/stride_dma_agen_test.sv
module stride_dma_agen_test;

    localparam int CNT_W = 16;
    localparam int MADDR_W = 32;
    localparam int SADDR_W = 14;

    logic               clk = 1'b0;
    logic               rst;
    logic               start_i;
    logic               dir_i;
    logic [CNT_W-1:0]   total_qw_i;
    logic [CNT_W-1:0]   chunk_qw_i;
    logic [CNT_W-1:0]   skip_qw_i;
    logic [MADDR_W-1:0] main_base_i;
    logic [SADDR_W-1:0] scr_base_i;
    logic               beat_valid_o;
    logic               beat_ready_i;
    logic [MADDR_W-1:0] beat_main_addr_o;
    logic [SADDR_W-1:0] beat_scr_addr_o;
    logic               beat_dir_o;
    logic [CNT_W-1:0]   remain_qw_o;
    logic               done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stride_dma_agen #(.CNT_W(CNT_W), .MADDR_W(MADDR_W), .SADDR_W(SADDR_W)) uut (
        .clk              (clk),
        .rst              (rst),
        .start_i          (start_i),
        .dir_i            (dir_i),
        .total_qw_i       (total_qw_i),
        .chunk_qw_i       (chunk_qw_i),
        .skip_qw_i        (skip_qw_i),
        .main_base_i      (main_base_i),
        .scr_base_i       (scr_base_i),
        .beat_valid_o     (beat_valid_o),
        .beat_ready_i     (beat_ready_i),
        .beat_main_addr_o (beat_main_addr_o),
        .beat_scr_addr_o  (beat_scr_addr_o),
        .beat_dir_o       (beat_dir_o),
        .remain_qw_o      (remain_qw_o),
        .done_o           (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected main byte address of beat k
    function automatic logic [31:0] exp_main(input logic [31:0] base, input int k,
                                             input int total, input int req, input int skip);
        int eff;
        longint c, off;
        eff = (req == 0 || req > total) ? total : req;
        c   = k / eff;
        off = k % eff;
        return base + 32'(16 * (c * (eff + skip) + off));
    endfunction

    function automatic logic [13:0] exp_scr(input logic [13:0] base, input int k);
        return 14'(base + 14'(16 * k));
    endfunction

    task automatic scramble_inputs();
        dir_i       = 1'($urandom);
        total_qw_i  = CNT_W'($urandom % 50);
        chunk_qw_i  = CNT_W'($urandom % 12);
        skip_qw_i   = CNT_W'($urandom % 9);
        main_base_i = {$urandom} & 32'hFFFF_FFF0;
        scr_base_i  = 14'($urandom) & 14'h3FF0;
    endtask

    task automatic run_xfer(input bit dir, input int total, input int req, input int skip,
                            input logic [31:0] mb, input logic [13:0] sb,
                            input int rdy_pct, input bit poke);
        int  k = 0;
        int  last_fire = -1;
        bit  got_done = 1'b0;
        bit  hold_pend = 1'b0;
        bit  poked = 1'b0;
        logic [31:0] h_main;
        logic [13:0] h_scr;
        logic [15:0] h_rem;
        @(negedge clk);
        dir_i = dir; total_qw_i = CNT_W'(total); chunk_qw_i = CNT_W'(req);
        skip_qw_i = CNT_W'(skip); main_base_i = mb; scr_base_i = sb;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        scramble_inputs();
        for (int cyc = 0; cyc < 5000 && !got_done; cyc++) begin
            start_i = 1'b0;
            if (hold_pend) begin
                chk(beat_main_addr_o == h_main && beat_scr_addr_o == h_scr && remain_qw_o == h_rem,
                    "R7", "stalled beat changed", longint'(beat_main_addr_o), longint'(h_main));
                hold_pend = 1'b0;
            end
            if (done_o) begin
                got_done = 1'b1;
                chk(k == total, "R1", "beats accepted", k, total);
                chk(remain_qw_o == 0, "R8", "remaining at done", remain_qw_o, 0);
                if (total == 0)
                    chk(cyc == 0, "R9", "empty done cycle", cyc, 0);
                else
                    chk(cyc == last_fire + 1, "R10", "done after last beat", cyc, last_fire + 1);
                chk(!beat_valid_o, "R1", "valid in done cycle", beat_valid_o, 0);
                if (poke) start_i = 1'b1;
            end else if (beat_valid_o) begin
                bit r;
                r = (($urandom % 100) < rdy_pct);
                beat_ready_i = r;
                if (poke && !poked && k == total / 2) begin
                    start_i = 1'b1;
                    poked = 1'b1;
                end
                if (r) begin
                    chk(beat_main_addr_o == exp_main(mb, k, total, req, skip),
                        (req == 0) ? "R3" : ((k % ((req == 0 || req > total) ? total : req)) == 0 ? "R6" : "R5"),
                        "main address", longint'(beat_main_addr_o),
                        longint'(exp_main(mb, k, total, req, skip)));
                    chk(beat_scr_addr_o == exp_scr(sb, k), "R4", "scratch address",
                        longint'(beat_scr_addr_o), longint'(exp_scr(sb, k)));
                    chk(beat_dir_o == dir, "R12", "direction", beat_dir_o, dir);
                    chk(remain_qw_o == 16'(total - k), "R8", "remaining count",
                        remain_qw_o, total - k);
                    k++;
                    last_fire = cyc;
                end else begin
                    h_main = beat_main_addr_o; h_scr = beat_scr_addr_o; h_rem = remain_qw_o;
                    hold_pend = 1'b1;
                end
            end else begin
                chk(1'b0, "R1", "valid dropped mid-transfer", 0, 1);
            end
            @(negedge clk);
        end
        beat_ready_i = 1'b0;
        start_i = 1'b0;
        if (!got_done) chk(1'b0, "R10", "no done seen", 0, 1);
        chk(!done_o, "R10", "done longer than one cycle", done_o, 0);
        chk(!beat_valid_o, "R11", "start in done cycle began a transfer", beat_valid_o, 0);
        chk(remain_qw_o == 0, "R8", "remaining after done", remain_qw_o, 0);
        @(negedge clk);
        chk(!beat_valid_o && !done_o, "R11", "idle after ignored start", beat_valid_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; start_i = 1'b0; beat_ready_i = 1'b0;
        dir_i = 1'b0; total_qw_i = '0; chunk_qw_i = '0; skip_qw_i = '0;
        main_base_i = '0; scr_base_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!beat_valid_o, "R1", "valid after reset", beat_valid_o, 0);
        chk(!done_o, "R10", "done after reset", done_o, 0);
        chk(remain_qw_o == 0, "R8", "remaining after reset", remain_qw_o, 0);

        // Directed corners
        run_xfer(1'b0, 0, 3, 2, 32'h0000_1000, 14'h0100, 100, 1'b0);  // R9
        run_xfer(1'b1, 10, 0, 4, 32'h0002_0000, 14'h0200, 100, 1'b0);  // R3 zero chunk
        run_xfer(1'b0, 7, 20, 3, 32'h0003_0000, 14'h0300, 60, 1'b0);   // R3 oversize chunk
        run_xfer(1'b1, 12, 4, 2, 32'h0004_0000, 14'h0400, 100, 1'b0);  // R2 even split
        run_xfer(1'b0, 11, 4, 5, 32'h0005_0000, 14'h3FC0, 50, 1'b0);   // R2 partial tail, R4 wrap
        run_xfer(1'b1, 9, 3, 0, 32'h0006_0000, 14'h0010, 30, 1'b0);    // gap zero
        run_xfer(1'b0, 8, 1, 1, 32'h0007_0000, 14'h0020, 20, 1'b1);    // R11 pokes, stalls
        run_xfer(1'b1, 1, 1, 7, 32'hFFFF_FFF0, 14'h0030, 100, 1'b1);   // single beat

        // Constrained random
        for (int t = 0; t < 40; t++) begin
            bit dr;
            int tot, rq, sk, pct;
            logic [31:0] mb;
            logic [13:0] sb;
            dr  = 1'($urandom);
            tot = $urandom % 41;
            rq  = $urandom % 10;
            sk  = $urandom % 6;
            pct = 20 + ($urandom % 81);
            mb  = {$urandom} & 32'h0FFF_FFF0;
            sb  = 14'($urandom) & 14'h3FF0;
            run_xfer(dr, tot, rq, sk, mb, sb, pct, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule